// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits beside the command arbiter of an SDRAM controller and takes care of keeping the array refreshed. An interval timer marks when refresh work falls due. In distributed mode that is one auto refresh per refresh interval. In burst mode it is a whole burst once per retention period. Work that falls due is added to a backlog counter. Whenever the banks report idle, the block drains the backlog one refresh at a time. After every auto refresh it holds NOP for the row-cycle time.

The block also runs self refresh through a level handshake. While `sr_req` is high and no refresh is owed, it waits for idle banks. It then issues the refresh command with CKE low and keeps CKE low while `sr_active` reports the device asleep. When `sr_req` falls, it raises CKE and holds NOP for the row-cycle time. In burst mode it then issues a full refresh burst.

`busy` tells the arbiter to keep off the command bus. It is raised combinationally in the cycle in which the block commits to a command, so the arbiter issues nothing in that cycle.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset `cmd_n` is 3'b111 (NOP), `cke` is 1, and `busy` and `sr_active` are 0.
- R2: `cmd_n` is {RAS#, CAS#, WE#}, where 3'b001 is refresh and 3'b111 is NOP. In distributed mode, one auto refresh falls due every REFI_NS/CLK_NS cycles. While the banks stay idle, each one is issued about one cycle after it falls due.
- R3: An auto refresh (refresh with `cke` high) is issued only if `banks_idle` was high and `cke` was high in the cycle before it.
- R4: After any refresh command, at least TRC_CYC cycles of NOP follow, where TRC_CYC is TRC_NS/CLK_NS rounded up. Back-to-back refreshes are exactly TRC_CYC+1 cycles apart.
- R5: `busy` is high in the decision cycle, during every command and NOP wait window, during self refresh and during the exit window. It is low when the block is idle with nothing to do.
- R6: Refreshes that fall due while `banks_idle` is low are counted. None is issued while the banks are busy. All of them are issued back to back once the banks are idle.
- R7: In distributed mode the backlog saturates at MAX_LAG. Further refreshes that fall due while it is full are dropped.
- R8: In burst mode, BURST_COUNT refreshes fall due every RETAIN_NS/CLK_NS cycles. They are issued back to back.
- R9: Self-refresh entry works as follows:
  - It needs `sr_req` high, `banks_idle` high and an empty backlog. Entry waits while the banks are busy.
  - Entry is one refresh command with `cke` low.
  - Then `sr_active` is high, `cke` is low and only NOPs follow, until `sr_req` falls.
- R10: Self-refresh exit works as follows:
  - `cke` rises in the cycle after `sr_active` is seen with `sr_req` low.
  - The first command after the rise comes exactly TRC_CYC+1 cycles after it.
- R11: In burst mode, BURST_COUNT back-to-back refreshes follow each self-refresh exit. In distributed mode none follow, and the interval timer restarts when the exit window ends.
- R12: An owed refresh has priority over self-refresh entry. A new `sr_req` raised during a post-exit burst enters self refresh only after the whole burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks precharged and idle, from bank tracking |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| cmd_n | output | 3 | {RAS#, CAS#, WE#}: 3'b001 refresh, 3'b111 NOP |
| cke | output | 1 | Clock enable toward the SDRAM |
| busy | output | 1 | Arbiter must leave the command bus alone |
| sr_active | output | 1 | Device is held in self refresh |

## Verification
The bench builds two instances with a 20 ns clock, a 70 ns row cycle (TRC_CYC of 4 after rounding up) and a 1 µs refresh interval of 50 cycles. The burst instance uses a burst of 8 over an 8 µs retention period of 400 cycles. These short periods put dozens of refresh ticks, a saturated backlog of 8 and several full bursts within a few thousand cycles. A burst of 8 keeps a post-exit burst short enough to raise a second self-refresh request in the middle of it. Random busy windows on the distributed instance check over 40 intervals that no refresh is lost or issued while the banks are busy.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_TRC,
        ST_SR_IN,
        ST_SR,
        ST_EXIT
    } seq_state_e;

    // {RAS#, CAS#, WE#}
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_AREF = 3'b001;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (PERIOD < 2) ? 1 : $clog2(PERIOD + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == TW'(PERIOD - 1));
        cnt_d = cnt_q + TW'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
    parameter int CAP = 8,
    parameter int ADD = 1,
    parameter int OW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add,
    input  logic          take,
    input  logic          clear,
    input  logic          load,
    input  logic [OW-1:0] load_val,
    output logic [OW-1:0] count
);
    logic [OW-1:0] cnt_d, cnt_q;
    logic [OW:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + (add ? (OW+1)'(ADD) : '0);
        if (sum > (OW+1)'(CAP)) begin
            sum = (OW+1)'(CAP);
        end
        if (take && (sum != '0)) begin
            sum = sum - (OW+1)'(1);
        end
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else begin
            cnt_d = sum[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int TRC_NS      = 63,
    parameter int REFI_NS     = 15600,
    parameter int RETAIN_NS   = 64000000,
    parameter bit BURST_MODE  = 1'b0,
    parameter int BURST_COUNT = 4096,
    parameter int MAX_LAG     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_idle,
    input  logic       sr_req,
    output logic [2:0] cmd_n,
    output logic       cke,
    output logic       busy,
    output logic       sr_active
);
    localparam int TRC_RAW  = (TRC_NS + CLK_NS - 1) / CLK_NS;
    localparam int TRC_CYC  = (TRC_RAW < 2) ? 2 : TRC_RAW;
    localparam int CW       = $clog2(TRC_CYC + 1);
    localparam int REFI_CYC = REFI_NS / CLK_NS;
    localparam int RET_CYC  = RETAIN_NS / CLK_NS;
    localparam int PERIOD   = BURST_MODE ? RET_CYC : REFI_CYC;
    localparam int ADD      = BURST_MODE ? BURST_COUNT : 1;
    localparam int CAP      = BURST_MODE ? 2 * BURST_COUNT : MAX_LAG;
    localparam int OW       = $clog2(CAP + 1);
    localparam logic [OW-1:0] EXIT_OWED = BURST_MODE ? OW'(BURST_COUNT) : '0;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] wcnt;
    } seq_t;

    seq_t          cur_q, nxt_d;
    logic          tick, timer_run;
    logic          take, clear, load;
    logic          go_ref, go_sr;
    logic [OW-1:0] owed;

    ref_interval_timer #(
        .PERIOD (PERIOD)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    ref_owed_ctr #(
        .CAP (CAP),
        .ADD (ADD),
        .OW  (OW)
    ) u_owed (
        .clk      (clk),
        .rst_n    (rst_n),
        .add      (tick),
        .take     (take),
        .clear    (clear),
        .load     (load),
        .load_val (EXIT_OWED),
        .count    (owed)
    );

    always_comb begin
        nxt_d  = cur_q;
        take   = 1'b0;
        clear  = 1'b0;
        load   = 1'b0;
        go_ref = (cur_q.st == ST_IDLE) && (owed != '0) && banks_idle;
        go_sr  = (cur_q.st == ST_IDLE) && (owed == '0) && banks_idle && sr_req;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (go_ref) begin
                    nxt_d.st = ST_REF;
                    take     = 1'b1;
                end else if (go_sr) begin
                    nxt_d.st = ST_SR_IN;
                    clear    = 1'b1;
                end
            end
            ST_REF: begin
                nxt_d.st   = ST_TRC;
                nxt_d.wcnt = CW'(TRC_CYC - 1);
            end
            ST_TRC, ST_EXIT: begin
                if (cur_q.wcnt <= CW'(1)) begin
                    nxt_d.st = ST_IDLE;
                end else begin
                    nxt_d.wcnt = cur_q.wcnt - CW'(1);
                end
            end
            ST_SR_IN: begin
                nxt_d.st = ST_SR;
            end
            ST_SR: begin
                if (!sr_req) begin
                    nxt_d.st   = ST_EXIT;
                    nxt_d.wcnt = CW'(TRC_CYC);
                    load       = 1'b1;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, wcnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        timer_run = (cur_q.st == ST_IDLE) || (cur_q.st == ST_REF) || (cur_q.st == ST_TRC);
        cmd_n     = ((cur_q.st == ST_REF) || (cur_q.st == ST_SR_IN)) ? CMD_AREF : CMD_NOP;
        cke       = !((cur_q.st == ST_SR_IN) || (cur_q.st == ST_SR));
        busy      = (cur_q.st != ST_IDLE) || go_ref || go_sr;
        sr_active = (cur_q.st == ST_SR);
    end
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk
    import sdram_ref_pkg::*;
#(
    parameter int TRC_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       banks_idle,
    input logic       sr_req,
    input logic [2:0] cmd_n,
    input logic       cke,
    input logic       busy,
    input logic       sr_active
);
    logic [31:0] since_cmd_q, since_rise_q;
    logic        cke_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd_q  <= '1;
            since_rise_q <= '1;
            cke_prev_q   <= 1'b1;
        end else begin
            if (cmd_n != CMD_NOP) begin
                since_cmd_q <= 32'd1;
            end else if (since_cmd_q != '1) begin
                since_cmd_q <= since_cmd_q + 32'd1;
            end
            if (cke && !cke_prev_q) begin
                since_rise_q <= 32'd1;
            end else if (since_rise_q != '1) begin
                since_rise_q <= since_rise_q + 32'd1;
            end
            cke_prev_q <= cke;
        end
    end

    // R3
    aref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_AREF && cke) |-> ($past(banks_idle) && $past(cke)));

    // R4
    trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n != CMD_NOP) |-> (since_cmd_q > 32'(TRC_CYC)));

    // R5
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n != CMD_NOP || !cke || sr_active) |-> busy);

    // R9
    sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!cke && cmd_n == CMD_NOP));

    // R9
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_AREF && !cke) |=> sr_active);

    // R10
    exit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && !sr_req) |=> cke);

    // R10
    exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n != CMD_NOP && cke) |-> (since_rise_q > 32'(TRC_CYC)));
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
    .TRC_CYC (TRC_CYC)
) u_sdram_refresh_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .sr_req     (sr_req),
    .cmd_n      (cmd_n),
    .cke        (cke),
    .busy       (busy),
    .sr_active  (sr_active)
);

// File: tb/sdram_refresh_seq_bench.sv
module sdram_refresh_seq_bench;
    localparam int CLK_NS = 20;
    localparam int TRC    = 4;    // ceil(70 / 20)
    localparam int REFI   = 50;   // 1000 / 20
    localparam int BC     = 8;
    localparam int LAG    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] idle = 2'b11;
    logic [1:0] srq = 2'b00;
    logic [1:0] idle_pe = 2'b11;
    logic [2:0] cmd_w [2];
    logic [1:0] cke_w, busy_w, sra_w;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ref_cnt [2] = '{0, 0};
    int sre_cnt [2] = '{0, 0};
    int last_ref [2] = '{-1000, -1000};
    int last_gap [2] = '{0, 0};
    int rise_t [2] = '{0, 0};
    int rise_gap [2] = '{-1, -1};
    bit cke_prev [2] = '{1'b1, 1'b1};
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    sdram_refresh_seq #(
        .CLK_NS (CLK_NS), .TRC_NS (70), .REFI_NS (1000), .RETAIN_NS (8000),
        .BURST_MODE (1'b0), .BURST_COUNT (BC), .MAX_LAG (LAG)
    ) u_sdram_refresh_seq (
        .clk (clk), .rst_n (rst_n), .banks_idle (idle[0]), .sr_req (srq[0]),
        .cmd_n (cmd_w[0]), .cke (cke_w[0]), .busy (busy_w[0]), .sr_active (sra_w[0])
    );

    sdram_refresh_seq #(
        .CLK_NS (CLK_NS), .TRC_NS (70), .REFI_NS (1000), .RETAIN_NS (8000),
        .BURST_MODE (1'b1), .BURST_COUNT (BC), .MAX_LAG (LAG)
    ) u_sdram_refresh_seq_burst (
        .clk (clk), .rst_n (rst_n), .banks_idle (idle[1]), .sr_req (srq[1]),
        .cmd_n (cmd_w[1]), .cke (cke_w[1]), .busy (busy_w[1]), .sr_active (sra_w[1])
    );

    function automatic int exp_ticks(int span, int period);
        return span / period;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        idle_pe <= idle;
    end

    // Event monitor: every refresh command is checked for R3 and R4
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (cmd_w[i] == 3'b001 && cke_w[i]) begin
                    ref_cnt[i]++;
                    chk(idle_pe[i] && cke_prev[i], "R3", {30'd0, idle_pe[i], cke_prev[i]}, 3);
                    chk(cyc - last_ref[i] >= TRC + 1, "R4", cyc - last_ref[i], TRC + 1);
                    last_gap[i] = cyc - last_ref[i];
                    last_ref[i] = cyc;
                    if (rise_gap[i] == 0) rise_gap[i] = cyc - rise_t[i];
                end
                if (cmd_w[i] == 3'b001 && !cke_w[i]) begin
                    sre_cnt[i]++;
                    last_ref[i] = cyc;
                end
                if (cke_w[i] && !cke_prev[i]) begin
                    rise_t[i]   = cyc;
                    rise_gap[i] = 0;
                end
                cke_prev[i] = cke_w[i];
            end
        end
    end

    task automatic seq_dist();
        int c0;
        int x;
        wait_cyc(75);
        chk(ref_cnt[0] == 1, "R2", ref_cnt[0], 1);
        chk(busy_w[0] == 1'b0, "R5", busy_w[0], 0);
        wait_cyc(225);
        chk(ref_cnt[0] == exp_ticks(225, REFI), "R2", ref_cnt[0], exp_ticks(225, REFI));
        // backlog of three
        idle[0] = 1'b0;
        wait_cyc(375);
        chk(ref_cnt[0] == 4, "R6", ref_cnt[0], 4);
        idle[0] = 1'b1;
        wait_cyc(395);
        chk(ref_cnt[0] == 7, "R6", ref_cnt[0], 7);
        chk(last_gap[0] == TRC + 1, "R4", last_gap[0], TRC + 1);
        wait_cyc(425);
        chk(ref_cnt[0] == 8, "R2", ref_cnt[0], 8);
        // saturation: twelve ticks while busy, capped at LAG
        idle[0] = 1'b0;
        wait_cyc(1025);
        chk(ref_cnt[0] == 8, "R6", ref_cnt[0], 8);
        idle[0] = 1'b1;
        wait_cyc(1075);
        chk(ref_cnt[0] == 8 + LAG + 1, "R7", ref_cnt[0], 8 + LAG + 1);
        // random busy windows
        c0 = ref_cnt[0];
        while (cyc < 2950) begin
            idle[0] = 1'b0;
            repeat ($urandom_range(19, 1)) @(negedge clk);
            idle[0] = 1'b1;
            repeat ($urandom_range(49, 10)) @(negedge clk);
        end
        idle[0] = 1'b1;
        wait_cyc(3075);
        chk(ref_cnt[0] - c0 == exp_ticks(2000, REFI), "R6", ref_cnt[0] - c0, exp_ticks(2000, REFI));
        // self refresh, distributed mode
        srq[0] = 1'b1;
        for (int k = 0; k < 10 && !sra_w[0]; k++) @(negedge clk);
        chk(sra_w[0] == 1'b1 && sre_cnt[0] == 1, "R9", sre_cnt[0], 1);
        c0 = ref_cnt[0];
        repeat (200) @(negedge clk);
        chk(ref_cnt[0] == c0 && cke_w[0] == 1'b0, "R9", ref_cnt[0], c0);
        chk(busy_w[0] == 1'b1, "R5", busy_w[0], 1);
        srq[0] = 1'b0;
        for (int k = 0; k < 10 && !cke_w[0]; k++) @(negedge clk);
        x = cyc;
        wait_cyc(x + TRC + 25);
        chk(ref_cnt[0] == c0, "R11", ref_cnt[0], c0);
        chk(busy_w[0] == 1'b0, "R5", busy_w[0], 0);
        wait_cyc(x + TRC + REFI + 10);
        chk(ref_cnt[0] == c0 + 1, "R11", ref_cnt[0], c0 + 1);
    endtask

    task automatic seq_burst();
        wait_cyc(390);
        chk(ref_cnt[1] == 0, "R8", ref_cnt[1], 0);
        wait_cyc(460);
        chk(ref_cnt[1] == BC, "R8", ref_cnt[1], BC);
        chk(last_gap[1] == TRC + 1, "R4", last_gap[1], TRC + 1);
        wait_cyc(500);
        idle[1] = 1'b0;
        srq[1]  = 1'b1;
        wait_cyc(520);
        chk(sra_w[1] == 1'b0 && cke_w[1] == 1'b1, "R9", sra_w[1], 0);
        idle[1] = 1'b1;
        for (int k = 0; k < 10 && !sra_w[1]; k++) @(negedge clk);
        chk(sra_w[1] == 1'b1 && cke_w[1] == 1'b0, "R9", sra_w[1], 1);
        chk(sre_cnt[1] == 1, "R9", sre_cnt[1], 1);
        wait_cyc(1000);
        chk(ref_cnt[1] == BC, "R9", ref_cnt[1], BC);
        chk(busy_w[1] == 1'b1, "R5", busy_w[1], 1);
        srq[1] = 1'b0;
        for (int k = 0; k < 10 && !cke_w[1]; k++) @(negedge clk);
        srq[1] = 1'b1;
        for (int k = 0; k < 200 && !sra_w[1]; k++) @(negedge clk);
        chk(rise_gap[1] == TRC + 1, "R10", rise_gap[1], TRC + 1);
        chk(ref_cnt[1] == 2 * BC, "R12", ref_cnt[1], 2 * BC);
        chk(sre_cnt[1] == 2, "R12", sre_cnt[1], 2);
        srq[1] = 1'b0;
        repeat (100) @(negedge clk);
        chk(ref_cnt[1] == 3 * BC, "R11", ref_cnt[1], 3 * BC);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(cmd_w[i] == 3'b111 && cke_w[i] && !busy_w[i] && !sra_w[i], "R1",
                {26'd0, cmd_w[i], cke_w[i], busy_w[i], sra_w[i]}, 32'b111100);
        end
        fork
            seq_dist();
            seq_burst();
        join
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule